// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port with Function Multiplexer

An eight-bit general-purpose pin port that a processor controls through a small byte-wide register bus. Each bit can serve as a plain input or output, connect to a timer channel, connect to a serial peripheral that owns the pin direction, or turn on a capacitive-sensing pin oscillator. The oscillator, the pad driver and the pull resistor are not modelled. The block drives them through control outputs: pin output value, output enable, pull enable, pull polarity and oscillator enable.

Each bit also watches its pin for an edge. A two-flop synchronizer feeds the detector, and a per-bit edge-select register picks the direction. A matching edge sets a sticky flag. Flags that are also enabled are ORed into a single port interrupt request. Software clears a flag by writing 0 to it.

Function selection uses two per-bit select registers: a primary select and a secondary select. The pair {primary, secondary} picks the function of the bit.

Top module: `gpio_edge_port`

## Requirements
- R1: With primary/secondary select `00`, the pin is plain I/O. `pin_oe` follows the direction register (1 = output) and `pin_out` follows the output register, one cycle after a register write.
- R2: With select `10`, the pin serves the timer. `pin_out` takes `tmr_out` and `pin_oe` follows the direction bit. When the direction bit is 0, `tmr_cap` carries the synchronized pin level; otherwise it is 0.
- R3: With select `11`, the pin serves the serial peripheral. `pin_out` takes `ser_out`, `pin_oe` takes `ser_oe`, and `ser_in` carries the synchronized pin level. `ser_in` is 0 in every other mode.
- R4: With select `01`, `osc_en` is 1 and `pin_oe` and `pin_out` are 0, whatever the direction bit holds.
- R5: When edge select is 0, a rising edge of the synchronized pin sets that bit's flag. When edge select is 1, a falling edge sets it. The flag is readable at offset 3 no later than four clock edges after the pin changes.
- R6: An edge of the opposite direction leaves the flag clear. Changing an edge-select bit while the pins are stable also leaves the flags clear.
- R7: Writing a flag bit stores the written value, so writing 0 clears the flag and writing 1 sets it. An edge detected in the same cycle as the write still sets its flag.
- R8: `irq` is the OR of all flags that have their enable bit set. It is registered and follows the flags by one cycle.
- R9: `pull_en` equals resistor-enable AND NOT `pin_oe`. `pull_up` equals the output register bit where the pull is enabled and 0 elsewhere.
- R10: Offset 0 always reads the synchronized pin level, and writes to offset 0 have no effect.
- R11: The register offsets are: input 0, output 1, direction 2, flag 3, edge select 4, interrupt enable 5, primary select 6, resistor enable 7, secondary select 8. Reads are registered with one cycle of latency, every register resets to 0, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Value driven to the pads |
| pin_oe | output | 8 | Pad output enable |
| pull_en | output | 8 | Pull resistor enable |
| pull_up | output | 8 | Pull polarity (1 = up) |
| osc_en | output | 8 | Pin oscillator enable |
| tmr_out | input | 8 | Timer output per bit |
| tmr_cap | output | 8 | Timer capture input per bit |
| ser_out | input | 8 | Serial peripheral output per bit |
| ser_oe | input | 8 | Serial peripheral direction per bit |
| ser_in | output | 8 | Serial peripheral input per bit |
| irq | output | 1 | Port interrupt request |

## Verification
The hardest situation to reach is one where a flag must stay clear even though something around it moved. This happens when an edge arrives in the direction that is not selected, or when the edge-select bit flips while the pin is stable. A missing flag only shows up if the bench reads it back after the synchronizer latency has passed. The stimulus therefore raises a pin whose edge select asks for a falling edge, waits past the synchronizer, and reads the flag register. It then lowers the pin to show that the selected edge does set the flag. Finally it clears the flags and toggles every edge-select bit with the pins held stable, and confirms through the flag register and `irq` that nothing was set.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_IN   = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_OUT  = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_FLAG = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_EDGE = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_SELA = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_REN  = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_SELB = 4'd8;

  // Encoding is {primary select, secondary select}
  typedef enum logic [1:0] {
    FN_GPIO   = 2'b00,
    FN_OSC    = 2'b01,
    FN_TIMER  = 2'b10,
    FN_SERIAL = 2'b11
  } pin_fn_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[s] <= '0;
      else     st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] fall_sel,
  input  logic [W-1:0] ien,
  input  logic         flag_wr,
  input  logic [W-1:0] flag_wdata,
  output logic [W-1:0] flags,
  output logic [W-1:0] evt,
  output logic         irq
);
  logic [W-1:0] lvl_d;
  logic [W-1:0] rise;
  logic [W-1:0] fall;

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;
  assign evt  = (rise & ~fall_sel) | (fall & fall_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d <= '0;
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      lvl_d <= lvl;
      if (flag_wr) flags <= flag_wdata | evt;
      else         flags <= flags | evt;
      irq <= |(flags & ien);
    end
  end
endmodule

// File: rtl/gpio_func_mux.sv
module gpio_func_mux
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sel_a,
  input  logic [W-1:0] sel_b,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] outr,
  input  logic [W-1:0] ren,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] tmr_out,
  input  logic [W-1:0] ser_out,
  input  logic [W-1:0] ser_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pull_en,
  output logic [W-1:0] pull_up,
  output logic [W-1:0] osc_en,
  output logic [W-1:0] tmr_cap,
  output logic [W-1:0] ser_in
);
  logic [W-1:0] n_out, n_oe, n_pen, n_pup, n_osc, n_cap, n_sin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    pin_fn_e fn;
    assign fn = pin_fn_e'({sel_a[i], sel_b[i]});

    assign n_out[i] = (fn == FN_GPIO)   ? outr[i]    :
                      (fn == FN_TIMER)  ? tmr_out[i] :
                      (fn == FN_SERIAL) ? ser_out[i] : 1'b0;
    assign n_oe[i]  = (fn == FN_GPIO || fn == FN_TIMER) ? dir[i] :
                      (fn == FN_SERIAL) ? ser_oe[i] : 1'b0;
    assign n_pen[i] = ren[i] & ~n_oe[i];
    assign n_pup[i] = n_pen[i] & outr[i];
    assign n_osc[i] = (fn == FN_OSC);
    assign n_cap[i] = (fn == FN_TIMER) & ~dir[i] & lvl[i];
    assign n_sin[i] = (fn == FN_SERIAL) & lvl[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0; pin_oe <= '0; pull_en <= '0; pull_up <= '0;
      osc_en  <= '0; tmr_cap <= '0; ser_in <= '0;
    end else begin
      pin_out <= n_out; pin_oe <= n_oe; pull_en <= n_pen; pull_up <= n_pup;
      osc_en  <= n_osc; tmr_cap <= n_cap; ser_in <= n_sin;
    end
  end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_port_pkg::*;
#(
  parameter int W         = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      pull_en,
  output logic [W-1:0]      pull_up,
  output logic [W-1:0]      osc_en,
  input  logic [W-1:0]      tmr_out,
  output logic [W-1:0]      tmr_cap,
  input  logic [W-1:0]      ser_out,
  input  logic [W-1:0]      ser_oe,
  output logic [W-1:0]      ser_in,
  output logic              irq
);
  logic [W-1:0] lvl;
  logic [W-1:0] outr, dir, fall_sel, ien, sel_a, sel_b, ren;
  logic [W-1:0] flags, evt;
  logic         flag_wr;

  gpio_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      outr <= '0; dir <= '0; fall_sel <= '0; ien <= '0;
      sel_a <= '0; sel_b <= '0; ren <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_OUT:  outr     <= bus_wdata;
        OFS_DIR:  dir      <= bus_wdata;
        OFS_EDGE: fall_sel <= bus_wdata;
        OFS_IEN:  ien      <= bus_wdata;
        OFS_SELA: sel_a    <= bus_wdata;
        OFS_REN:  ren      <= bus_wdata;
        OFS_SELB: sel_b    <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign flag_wr = bus_wr && (bus_addr == OFS_FLAG);

  gpio_edge_flags #(.W(W)) u_flags (
    .clk(clk), .rst(rst), .lvl(lvl), .fall_sel(fall_sel), .ien(ien),
    .flag_wr(flag_wr), .flag_wdata(bus_wdata),
    .flags(flags), .evt(evt), .irq(irq)
  );

  gpio_func_mux #(.W(W)) u_mux (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .dir(dir),
    .outr(outr), .ren(ren), .lvl(lvl), .tmr_out(tmr_out),
    .ser_out(ser_out), .ser_oe(ser_oe),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
    .pull_up(pull_up), .osc_en(osc_en), .tmr_cap(tmr_cap), .ser_in(ser_in)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        OFS_IN:   bus_rdata <= lvl;
        OFS_OUT:  bus_rdata <= outr;
        OFS_DIR:  bus_rdata <= dir;
        OFS_FLAG: bus_rdata <= flags;
        OFS_EDGE: bus_rdata <= fall_sel;
        OFS_IEN:  bus_rdata <= ien;
        OFS_SELA: bus_rdata <= sel_a;
        OFS_REN:  bus_rdata <= ren;
        OFS_SELB: bus_rdata <= sel_b;
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      sel_a,
  input logic [W-1:0]      sel_b,
  input logic [W-1:0]      ien,
  input logic [W-1:0]      flags,
  input logic [W-1:0]      evt,
  input logic [W-1:0]      pin_oe,
  input logic [W-1:0]      pull_en,
  input logic              irq
);
  assert_osc_no_drive_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_oe & $past(~sel_a & sel_b)) == '0));

  assert_no_pull_on_output_R9: assert property (@(posedge clk) disable iff (rst)
    (pull_en & pin_oe) == '0);

  assert_flag_needs_cause_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((flags & ~$past(flags) & ~$past(evt)) == '0) ||
              $past(bus_wr && bus_addr == OFS_FLAG)));

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_FLAG && bus_wdata == '0 && evt == '0)
      |=> (flags == '0));

  assert_irq_tracks_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(flags & ien))));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .sel_a(sel_a), .sel_b(sel_b), .ien(ien),
  .flags(flags), .evt(evt), .pin_oe(pin_oe), .pull_en(pull_en), .irq(irq)
);

// File: tb/sim_gpio_edge_port.sv
`timescale 1ns/1ps
module sim_gpio_edge_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0, pin_out, pin_oe, pull_en, pull_up, osc_en;
  logic [7:0] tmr_out = '0, tmr_cap, ser_out = '0, ser_oe = '0, ser_in;
  logic       irq;

  int total = 0, bad = 0;
  bit done = 0, rd_pend = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  gpio_edge_port u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en), .pull_up(pull_up),
    .osc_en(osc_en), .tmr_out(tmr_out), .tmr_cap(tmr_cap), .ser_out(ser_out),
    .ser_oe(ser_oe), .ser_in(ser_in), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  // Scoreboard driver: queue the expected read value, then present the address
  task automatic rd_expect(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); bus_addr = a; exp_q.push_back(e); tag_q.push_back(tag); rd_pend = 1;
    @(negedge clk); rd_pend = 0;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] e);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, e);
    end
  endtask

  // Scoreboard monitor: compare registered read data after the sampling edge
  initial begin
    forever begin
      @(posedge clk);
      if (rd_pend) begin
        #1;
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(4); rst = 1'b0; tick(2);
    // R11 reset state and map
    chk("R11 reset pin_oe", pin_oe, 8'h00);
    chk("R11 reset irq", {7'd0, irq}, 8'h00);
    for (int a = 0; a < 9; a++) rd_expect(4'(a), 8'h00, "R11 reset read");
    rd_expect(4'd9, 8'h00, "R11 unmapped");

    // R1 plain I/O
    wr(4'd2, 8'h0F); wr(4'd1, 8'hA5); tick(2);
    chk("R1 pin_oe", pin_oe, 8'h0F);
    chk("R1 pin_out", pin_out, 8'hA5);
    rd_expect(4'd1, 8'hA5, "R11 out readback");
    rd_expect(4'd2, 8'h0F, "R11 dir readback");

    // R10 input register
    pin_in = 8'h3C; tick(4);
    rd_expect(4'd0, 8'h3C, "R10 input level");
    wr(4'd0, 8'hFF);
    rd_expect(4'd0, 8'h3C, "R10 write ignored");

    // R9 pull
    wr(4'd7, 8'hFF); tick(2);
    chk("R9 pull_en", pull_en, 8'hF0);
    chk("R9 pull_up", pull_up, 8'hA0);

    // R2 timer
    wr(4'd6, 8'h03); wr(4'd2, 8'h01); tmr_out = 8'hFF; pin_in = 8'hFF; tick(5);
    chk("R2 pin_out", pin_out, 8'hA7);
    chk("R2 pin_oe", pin_oe, 8'h01);
    chk("R2 tmr_cap", tmr_cap, 8'h02);
    chk("R9 pull_en timer", pull_en, 8'hFE);

    // R3 serial
    wr(4'd6, 8'h30); wr(4'd8, 8'h30); tmr_out = 8'h00;
    ser_out = 8'h10; ser_oe = 8'h30; tick(2);
    chk("R3 pin_out", pin_out, 8'h95);
    chk("R3 pin_oe", pin_oe, 8'h31);
    chk("R3 ser_in", ser_in, 8'h30);
    chk("R2 tmr_cap idle", tmr_cap, 8'h00);

    // R4 oscillator
    wr(4'd6, 8'h00); wr(4'd8, 8'hC0); wr(4'd2, 8'hFF); tick(2);
    chk("R4 pin_oe", pin_oe, 8'h3F);
    chk("R4 osc_en", osc_en, 8'hC0);
    chk("R4 pin_out", pin_out, 8'h25);
    chk("R3 ser_in idle", ser_in, 8'h00);
    wr(4'd8, 8'h00); wr(4'd2, 8'h00);

    // R5 rising edge
    pin_in = 8'h00; tick(5); wr(4'd3, 8'h00); wr(4'd4, 8'h00); wr(4'd5, 8'h00);
    rd_expect(4'd3, 8'h00, "R7 flags cleared");
    pin_in = 8'h01; tick(4);
    rd_expect(4'd3, 8'h01, "R5 rising sets flag");
    chk("R8 irq masked", {7'd0, irq}, 8'h00);
    wr(4'd5, 8'h01); tick(2);
    chk("R8 irq enabled", {7'd0, irq}, 8'h01);
    wr(4'd3, 8'h00); tick(2);
    chk("R7 irq after clear", {7'd0, irq}, 8'h00);
    rd_expect(4'd3, 8'h00, "R7 write 0 clears");

    // R6 wrong edge, then R5 falling edge
    wr(4'd4, 8'h02); pin_in = 8'h03; tick(5);
    rd_expect(4'd3, 8'h00, "R6 rising ignored when falling selected");
    pin_in = 8'h01; tick(4);
    rd_expect(4'd3, 8'h02, "R5 falling sets flag");
    wr(4'd3, 8'h00);
    wr(4'd4, 8'hFF); tick(3); wr(4'd4, 8'h00); tick(3);
    rd_expect(4'd3, 8'h00, "R6 edge select change sets nothing");
    chk("R6 irq quiet", {7'd0, irq}, 8'h00);

    // R7 write 1 sets, R8 OR of enabled flags
    wr(4'd3, 8'h80);
    rd_expect(4'd3, 8'h80, "R7 write 1 sets");
    wr(4'd5, 8'h81); tick(2);
    chk("R8 irq from bit7", {7'd0, irq}, 8'h01);
    wr(4'd3, 8'h00); tick(2);
    chk("R8 irq drops", {7'd0, irq}, 8'h00);

    tick(3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule